// File: doc/BRIEF.md
# Serial Program/Verify Command Slave

This block is the target-side engine of a two-wire serial programming port. A host drives a serial clock and a shared data line. Every transaction opens with a 6-bit command, and some commands are followed by a 16-bit data frame. The block keeps a 14-bit program counter (PC) and a load latch. It reaches a word memory, which holds user program words and a small configuration region, and a 128-byte data memory. Both memories sit outside the block and are reached through synchronous ports with a one-cycle read latency.

The serial pins are not used as a clock. Both lines are synchronised into the system clock domain, and their edges are detected there. Program and erase operations are modelled as a busy window whose length is set by parameters. The memory write takes place in the last cycle of that window. A `mode_en` input stands in for programming-mode entry: while it is low, the engine is held in its idle state with the PC at zero.

Top module: `spv_cmd_slave`

## Requirements
- R1: After reset, and in the cycle after `mode_en` is seen low, the PC is 0, `ser_dat_oe` is 0 and `busy` is 0. After reset `err_cnt` is 0.
- R2: Commands are 6 bits and data frames are 16 bits. Both are sampled on falling serial-clock edges, LSb first. Load-program (low nibble 0010) followed by erase+program (full code 001000) writes the 14 loaded bits (frame bits 14:1) to the word at the PC.
- R3: Read-program (low nibble 0100) returns the word at the PC as a frame: bit 0 is zero, bits 14:1 carry the word and bit 15 is zero. The block changes the data line on each rising edge. `ser_dat_oe` rises on the 2nd rising edge of the frame and drops after the 16th falling edge.
- R4: Load-data-memory (low nibble 0011) takes frame bits 8:1 as the byte. Read-data-memory (low nibble 0101) returns the byte in frame bits 8:1 and zeros in all other bits. Both use PC[6:0] as the byte address.
- R5: Increment (low nibble 0110) adds 1 to the low PC bits and leaves the top bit unchanged, so the user region wraps from its top to 0. A user word address is the PC masked to `PMEM_AW` bits.
- R6: Load-configuration (low nibble 0000) sets the PC to the configuration base, which has only the top bit set. Increments then wrap back to that base. In the configuration region, PC offsets 8 to 15 read as all ones and are never written.
- R7: Program-only (full code 011000) writes the bitwise AND of the loaded word and the stored word. Erase+program replaces the stored word.
- R8: `busy` stays high for exactly `ERASE_CYCLES+PROG_CYCLES` cycles after erase+program and for exactly `PROG_CYCLES` cycles after program-only.
- R9: A command that completes while `busy` is high has no effect and adds 1 to `err_cnt`.
- R10: Bulk-erase-program (low nibble 1001) writes 0x3FFF to all 2^`PMEM_AW` user words, with `busy` high for 2^`PMEM_AW` cycles. Bulk-erase-data (low nibble 1011) writes 0xFF to all 128 bytes, with `busy` high for 128 cycles.
- R11: Dropping `mode_en` and raising it again returns the PC to the user region at address 0.
- R12: Setup codes 000001 and 000111, and codes that match no command, change nothing: no busy window, no frame, and no change to the PC or `err_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Programming mode active; low holds the engine idle |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat_in | input | 1 | Value seen on the data line |
| ser_dat_out | output | 1 | Value driven onto the data line during reads |
| ser_dat_oe | output | 1 | Drive enable for the data line |
| pmem_addr | output | PMEM_AW+1 | Word address; the top bit selects the configuration region |
| pmem_re | output | 1 | Word memory read strobe |
| pmem_we | output | 1 | Word memory write strobe |
| pmem_wdata | output | 14 | Word write data |
| pmem_rdata | input | 14 | Word read data, one cycle after the strobe |
| dmem_addr | output | 7 | Byte address |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Byte write data |
| dmem_rdata | input | 8 | Byte read data, one cycle after the strobe |
| busy | output | 1 | Program or erase window in progress |
| err_cnt | output | ERR_W | Saturating count of commands rejected while busy |

## Verification
The case hardest to reach is a command that completes inside a busy window. A serial command takes several times longer than a short program window. The bench therefore sets long cycle counts and sends an increment straight after an erase+program, so that the increment's sixth falling edge lands while the window is still open. The split wrap needs hundreds of increments to reach the edge of each region. The bench makes these runs short by shrinking the PC width and the word-memory size through parameters.

// File: rtl/spv_pkg.sv
package spv_pkg;
    localparam int WORD_W  = 14;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 6;
    localparam int BYTE_W  = 8;
    localparam int DADDR_W = 7;

    typedef enum logic [3:0] {
        OP_NONE, OP_LD_CFG, OP_LD_PGM, OP_LD_DAT, OP_INC, OP_RD_PGM,
        OP_RD_DAT, OP_PROG_ER, OP_PROG_ONLY, OP_BULK_PGM, OP_BULK_DAT, OP_SETUP
    } op_e;

    typedef enum logic [1:0] {PH_CMD, PH_LOAD, PH_READ} phase_e;

    // Full 6-bit codes first; the rest decode on the low nibble only.
    function automatic op_e decode_op(input logic [CMD_W-1:0] c);
        op_e r;
        r = OP_NONE;
        if (c == 6'b001000)                          r = OP_PROG_ER;
        else if (c == 6'b011000)                     r = OP_PROG_ONLY;
        else if (c == 6'b000001 || c == 6'b000111)   r = OP_SETUP;
        else begin
            case (c[3:0])
                4'b0000: r = OP_LD_CFG;
                4'b0010: r = OP_LD_PGM;
                4'b0011: r = OP_LD_DAT;
                4'b0110: r = OP_INC;
                4'b0100: r = OP_RD_PGM;
                4'b0101: r = OP_RD_DAT;
                4'b1001: r = OP_BULK_PGM;
                4'b1011: r = OP_BULK_DAT;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [FRAME_W-1:0] frame_word(input logic [WORD_W-1:0] w);
        return {1'b0, w, 1'b0};
    endfunction

    function automatic logic [FRAME_W-1:0] frame_byte(input logic [BYTE_W-1:0] b);
        return {{(FRAME_W-BYTE_W-1){1'b0}}, b, 1'b0};
    endfunction
endpackage

// File: rtl/spv_pin_sync.sv
module spv_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic rise,
    output logic fall,
    output logic dat
);
    logic [STAGES:0]   ck_sr;
    logic [STAGES-1:0] dt_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sr <= '0;
            dt_sr <= '0;
        end else begin
            ck_sr <= {ck_sr[STAGES-1:0], ser_clk};
            dt_sr <= {dt_sr[STAGES-2:0], ser_dat};
        end
    end

    assign rise = ck_sr[STAGES-1] & ~ck_sr[STAGES];
    assign fall = ~ck_sr[STAGES-1] & ck_sr[STAGES];
    assign dat  = dt_sr[STAGES-1];
endmodule

// File: rtl/spv_busy_timer.sv
module spv_busy_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          active,
    output logic          done,
    output logic [CW-1:0] idx
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
            idx <= '0;
        end else if (start) begin
            cnt <= len;
            idx <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            idx <= idx + 1'b1;
        end
    end

    assign active = (cnt != '0);
    assign done   = (cnt == CW'(1));
endmodule

// File: rtl/spv_tx_shift.sv
module spv_tx_shift import spv_pkg::*; (
    input  logic               clk,
    input  logic               clr,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               rise,
    input  logic               stop,
    output logic               dout,
    output logic               oe
);
    logic [FRAME_W-1:0] sr;
    logic armed, first_seen;

    always_ff @(posedge clk) begin
        if (clr || stop) begin
            sr <= '0; armed <= 1'b0; first_seen <= 1'b0;
            dout <= 1'b0; oe <= 1'b0;
        end else if (load) begin
            sr <= frame; armed <= 1'b1; first_seen <= 1'b0;
            dout <= 1'b0; oe <= 1'b0;
        end else if (armed && rise) begin
            dout       <= sr[0];
            sr         <= sr >> 1;
            first_seen <= 1'b1;
            if (first_seen) oe <= 1'b1;
        end
    end
endmodule

// File: rtl/spv_cmd_slave.sv
module spv_cmd_slave import spv_pkg::*; #(
    parameter int PC_W         = 14,
    parameter int PMEM_AW      = 11,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 24,
    parameter int ERR_W        = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_en,
    input  logic               ser_clk,
    input  logic               ser_dat_in,
    output logic               ser_dat_out,
    output logic               ser_dat_oe,
    output logic [PMEM_AW:0]   pmem_addr,
    output logic               pmem_re,
    output logic               pmem_we,
    output logic [WORD_W-1:0]  pmem_wdata,
    input  logic [WORD_W-1:0]  pmem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_re,
    output logic               dmem_we,
    output logic [BYTE_W-1:0]  dmem_wdata,
    input  logic [BYTE_W-1:0]  dmem_rdata,
    output logic               busy,
    output logic [ERR_W-1:0]   err_cnt
);
    localparam int SWEEP_P = 1 << PMEM_AW;
    localparam int SWEEP_D = 1 << DADDR_W;
    localparam int LEN_EP  = ERASE_CYCLES + PROG_CYCLES;
    localparam int MAX_A   = (LEN_EP > SWEEP_P) ? LEN_EP : SWEEP_P;
    localparam int MAX_B   = (MAX_A > SWEEP_D) ? MAX_A : SWEEP_D;
    localparam int CW      = $clog2(MAX_B + 1);
    localparam logic [PC_W-1:0] CFG_BASE = {1'b1, {(PC_W-1){1'b0}}};

    logic clr;
    logic s_rise, s_fall, s_dat;
    phase_e phase;
    logic [3:0] bitcnt;
    logic [CMD_W-1:0] cmd_sr, cmd_full;
    logic [FRAME_W-1:0] fr_sr, fr_full, tx_frame;
    logic [PC_W-1:0] pc;
    logic [WORD_W-1:0] latch, old_q;
    logic ld_dmem, tgt_dm, erase_q, sweep_on, sweep_dm, re_q, cap_q;
    logic cmd_end, accept, reject, frm_end, in_cfg, cfg_void, wr_pc;
    op_e op;
    logic tmr_start;
    logic [CW-1:0] tmr_len, t_idx;
    logic t_active, t_done;

    assign clr = rst | ~mode_en;

    spv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(clr), .ser_clk(ser_clk), .ser_dat(ser_dat_in),
        .rise(s_rise), .fall(s_fall), .dat(s_dat));

    assign cmd_full = {s_dat, cmd_sr[CMD_W-1:1]};
    assign fr_full  = {s_dat, fr_sr[FRAME_W-1:1]};
    assign op       = decode_op(cmd_full);
    assign cmd_end  = (phase == PH_CMD) && s_fall && (bitcnt == 4'(CMD_W-1));
    assign accept   = cmd_end && !t_active;
    assign reject   = cmd_end && t_active;
    assign frm_end  = (phase != PH_CMD) && s_fall && (bitcnt == 4'(FRAME_W-1));
    assign in_cfg   = pc[PC_W-1];
    assign cfg_void = in_cfg & pc[3];

    always_comb begin
        tmr_start = accept;
        case (op)
            OP_PROG_ER:   tmr_len = CW'(LEN_EP);
            OP_PROG_ONLY: tmr_len = CW'(PROG_CYCLES);
            OP_BULK_PGM:  tmr_len = CW'(SWEEP_P);
            OP_BULK_DAT:  tmr_len = CW'(SWEEP_D);
            default: begin
                tmr_len   = '0;
                tmr_start = 1'b0;
            end
        endcase
    end

    spv_busy_timer #(.CW(CW)) u_timer (
        .clk(clk), .clr(clr), .start(tmr_start), .len(tmr_len),
        .active(t_active), .done(t_done), .idx(t_idx));

    assign busy = t_active;

    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= PH_CMD; bitcnt <= '0; cmd_sr <= '0; fr_sr <= '0;
            pc <= '0; latch <= '0; old_q <= '0;
            ld_dmem <= 1'b0; tgt_dm <= 1'b0; erase_q <= 1'b0;
            sweep_on <= 1'b0; sweep_dm <= 1'b0; re_q <= 1'b0; cap_q <= 1'b0;
        end else begin
            re_q  <= 1'b0;
            cap_q <= re_q;
            if (cap_q && phase != PH_READ)
                old_q <= tgt_dm ? WORD_W'(dmem_rdata) : pmem_rdata;
            if (t_done) sweep_on <= 1'b0;
            if (s_fall) begin
                if (phase == PH_CMD) begin
                    if (bitcnt == 4'(CMD_W-1)) begin
                        bitcnt <= '0;
                        cmd_sr <= '0;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        cmd_sr <= cmd_full;
                    end
                end else begin
                    fr_sr <= fr_full;
                    if (bitcnt == 4'(FRAME_W-1)) begin
                        bitcnt <= '0;
                        phase  <= PH_CMD;
                        if (phase == PH_LOAD)
                            latch <= ld_dmem ? WORD_W'(fr_full[BYTE_W:1]) : fr_full[WORD_W:1];
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
            end
            if (accept) begin
                case (op)
                    OP_LD_CFG: begin pc <= CFG_BASE; phase <= PH_LOAD; ld_dmem <= 1'b0; end
                    OP_LD_PGM: begin phase <= PH_LOAD; ld_dmem <= 1'b0; end
                    OP_LD_DAT: begin phase <= PH_LOAD; ld_dmem <= 1'b1; end
                    OP_INC:    pc <= {pc[PC_W-1], pc[PC_W-2:0] + 1'b1};
                    OP_RD_PGM: begin phase <= PH_READ; tgt_dm <= 1'b0; re_q <= 1'b1; end
                    OP_RD_DAT: begin phase <= PH_READ; tgt_dm <= 1'b1; re_q <= 1'b1; end
                    OP_PROG_ER, OP_PROG_ONLY: begin
                        tgt_dm   <= ld_dmem;
                        erase_q  <= (op == OP_PROG_ER);
                        re_q     <= 1'b1;
                        sweep_on <= 1'b0;
                    end
                    OP_BULK_PGM: begin sweep_on <= 1'b1; sweep_dm <= 1'b0; end
                    OP_BULK_DAT: begin sweep_on <= 1'b1; sweep_dm <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                           err_cnt <= '0;
        else if (reject && err_cnt != '1)  err_cnt <= err_cnt + 1'b1;
    end

    // Read data to the serial line
    assign tx_frame = tgt_dm ? frame_byte(dmem_rdata)
                             : frame_word(cfg_void ? {WORD_W{1'b1}} : pmem_rdata);

    spv_tx_shift u_tx (
        .clk(clk), .clr(clr), .load(cap_q && phase == PH_READ), .frame(tx_frame),
        .rise(s_rise), .stop(frm_end && phase == PH_READ),
        .dout(ser_dat_out), .oe(ser_dat_oe));

    // Memory ports
    assign wr_pc   = t_done && !sweep_on;
    assign pmem_re = re_q & ~tgt_dm;
    assign dmem_re = re_q & tgt_dm;
    assign pmem_we = (sweep_on && t_active && !sweep_dm) || (wr_pc && !tgt_dm && !cfg_void);
    assign dmem_we = (sweep_on && t_active && sweep_dm) || (wr_pc && tgt_dm);

    always_comb begin
        if (sweep_on)    pmem_addr = {1'b0, t_idx[PMEM_AW-1:0]};
        else if (in_cfg) pmem_addr = {1'b1, PMEM_AW'(pc[2:0])};
        else             pmem_addr = {1'b0, pc[PMEM_AW-1:0]};
        dmem_addr  = sweep_on ? t_idx[DADDR_W-1:0] : pc[DADDR_W-1:0];
        pmem_wdata = sweep_on ? {WORD_W{1'b1}} : (erase_q ? latch : (latch & old_q));
        dmem_wdata = sweep_on ? {BYTE_W{1'b1}}
                   : (erase_q ? latch[BYTE_W-1:0] : (latch[BYTE_W-1:0] & old_q[BYTE_W-1:0]));
    end
endmodule

// File: rtl/spv_cmd_slave_chk.sv
module spv_cmd_slave_chk #(
    parameter int PC_W  = 14,
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_en,
    input logic             busy,
    input logic             oe,
    input logic             pmem_we,
    input logic             dmem_we,
    input logic [ERR_W-1:0] err_cnt,
    input logic [PC_W-1:0]  pc,
    input logic             rise,
    input logic             fall
);
    assert_err_step_R9: assert property (@(posedge clk) disable iff (rst)
        (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));

    assert_write_in_window_R8: assert property (@(posedge clk) disable iff (rst)
        (pmem_we || dmem_we) |-> busy);

    assert_cfg_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_en && $past(mode_en) && $past(pc[PC_W-1])) |-> pc[PC_W-1]);

    assert_drive_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(rise));

    assert_mode_exit_R1: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> (pc == '0 && !oe && !busy));

    assert_pc_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_en && $past(mode_en) && pc != $past(pc)) |-> $past(fall));
endmodule

bind spv_cmd_slave spv_cmd_slave_chk #(.PC_W(PC_W), .ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst(rst), .mode_en(mode_en), .busy(busy), .oe(ser_dat_oe),
    .pmem_we(pmem_we), .dmem_we(dmem_we), .err_cnt(err_cnt), .pc(pc),
    .rise(s_rise), .fall(s_fall));

// File: tb/sim_spv_cmd_slave.sv
module sim_spv_cmd_slave;
    localparam int PC_W = 9, AW = 6, PROG = 150, ERASE = 100, H = 5;
    localparam logic [5:0] C_LD_CFG = 6'b000000, C_LD_PGM = 6'b000010, C_LD_DAT = 6'b000011,
        C_INC = 6'b000110, C_RD_PGM = 6'b000100, C_RD_DAT = 6'b000101, C_ER_PG = 6'b001000,
        C_PG_ONLY = 6'b011000, C_BULK_P = 6'b001001, C_BULK_D = 6'b001011;

    logic clk = 0, rst = 1, mode_en = 0, ser_clk = 0, host_dat = 0;
    logic ser_dat_out, ser_dat_oe, pmem_re, pmem_we, dmem_re, dmem_we, busy;
    logic [AW:0] pmem_addr;
    logic [13:0] pmem_wdata, pmem_rdata;
    logic [6:0] dmem_addr;
    logic [7:0] dmem_wdata, dmem_rdata;
    logic [7:0] err_cnt;
    logic pin;
    logic [13:0] puser [64];
    logic [13:0] pcfg [8];
    logic [7:0] dmem [128];
    int n_chk = 0, n_fail = 0, busy_seen = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;
    assign pin = ser_dat_oe ? ser_dat_out : host_dat;

    spv_cmd_slave #(.PC_W(PC_W), .PMEM_AW(AW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) u0 (
        .clk(clk), .rst(rst), .mode_en(mode_en), .ser_clk(ser_clk), .ser_dat_in(pin),
        .ser_dat_out(ser_dat_out), .ser_dat_oe(ser_dat_oe), .pmem_addr(pmem_addr),
        .pmem_re(pmem_re), .pmem_we(pmem_we), .pmem_wdata(pmem_wdata), .pmem_rdata(pmem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .busy(busy), .err_cnt(err_cnt));

    always @(posedge clk) begin
        if (busy) busy_seen <= busy_seen + 1;
        if (pmem_we) begin
            if (pmem_addr[AW]) pcfg[pmem_addr[2:0]] <= pmem_wdata;
            else               puser[pmem_addr[AW-1:0]] <= pmem_wdata;
        end
        if (pmem_re) pmem_rdata <= pmem_addr[AW] ? pcfg[pmem_addr[2:0]] : puser[pmem_addr[AW-1:0]];
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        if (dmem_re) dmem_rdata <= dmem[dmem_addr];
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            host_dat = v[i];
            tick(H); ser_clk = 1;
            tick(H); ser_clk = 0;
            tick(H);
        end
    endtask

    task automatic cmd(input logic [5:0] c);
        send_bits({10'b0, c}, 6);
    endtask

    task automatic load_word(input logic [5:0] c, input logic [13:0] w);
        cmd(c); send_bits({1'b0, w, 1'b0}, 16);
    endtask

    task automatic incs(input int n);
        for (int i = 0; i < n; i++) cmd(C_INC);
    endtask

    task automatic wait_idle();
        tick(2);
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic read_frame(input logic [5:0] c, output logic [15:0] got, output bit oe_ok);
        oe_ok = 1;
        cmd(c);
        host_dat = 0;
        if (ser_dat_oe !== 1'b0) oe_ok = 0;
        for (int k = 1; k <= 16; k++) begin
            tick(H); ser_clk = 1;
            tick(H);
            got[k-1] = ser_dat_out;
            if (ser_dat_oe !== (k >= 2)) oe_ok = 0;
            ser_clk = 0;
            tick(H);
        end
        tick(2);
        if (ser_dat_oe !== 1'b0) oe_ok = 0;
    endtask

    task automatic t_reset();
        chk(ser_dat_oe == 0, "R1 oe after reset", 32'(ser_dat_oe), 0);
        chk(busy == 0, "R1 busy after reset", 32'(busy), 0);
        chk(err_cnt == 0, "R1 err_cnt after reset", 32'(err_cnt), 0);
    endtask

    task automatic t_erase_program();
        load_word(C_LD_PGM, 14'h2A5C);
        busy_seen = 0;
        cmd(C_ER_PG); wait_idle();
        chk(puser[0] == 14'h2A5C, "R2 erase+program word", 32'(puser[0]), 32'h2A5C);
        chk(busy_seen == ERASE + PROG, "R8 erase+program busy", busy_seen, ERASE + PROG);
    endtask

    task automatic t_read_program();
        logic [15:0] got; bit ok;
        read_frame(C_RD_PGM, got, ok);
        chk(got == {1'b0, 14'h2A5C, 1'b0}, "R3 read frame", 32'(got), 32'({1'b0, 14'h2A5C, 1'b0}));
        chk(ok, "R3 oe turnaround", 32'(ok), 1);
    endtask

    task automatic t_program_only();
        load_word(C_LD_PGM, 14'h1555);
        busy_seen = 0;
        cmd(C_PG_ONLY); wait_idle();
        chk(puser[0] == 14'h0054, "R7 program-only AND", 32'(puser[0]), 32'h54);
        chk(busy_seen == PROG, "R8 program-only busy", busy_seen, PROG);
    endtask

    task automatic t_data_mem();
        logic [15:0] got; bit ok;
        cmd(C_INC);
        cmd(C_LD_DAT); send_bits({7'b0, 8'hA7, 1'b0}, 16);
        cmd(C_ER_PG); wait_idle();
        chk(dmem[1] == 8'hA7, "R4 data byte write", 32'(dmem[1]), 32'hA7);
        chk(puser[1] == 14'h3FFF, "R4 word memory untouched", 32'(puser[1]), 32'h3FFF);
        read_frame(C_RD_DAT, got, ok);
        chk(got == {7'b0, 8'hA7, 1'b0}, "R4 data read frame", 32'(got), 32'({7'b0, 8'hA7, 1'b0}));
    endtask

    task automatic t_user_wrap();
        logic [15:0] got; bit ok;
        incs(63);
        load_word(C_LD_PGM, 14'h0123); cmd(C_ER_PG); wait_idle();
        chk(puser[0] == 14'h0123, "R5 address masking", 32'(puser[0]), 32'h123);
        incs(191);
        load_word(C_LD_PGM, 14'h0777); cmd(C_ER_PG); wait_idle();
        chk(puser[63] == 14'h0777, "R5 top user word", 32'(puser[63]), 32'h777);
        cmd(C_INC);
        read_frame(C_RD_PGM, got, ok);
        chk(got[14:1] == 14'h0123, "R5 user wrap to zero", 32'(got[14:1]), 32'h123);
    endtask

    task automatic t_busy_reject();
        logic [15:0] got; bit ok;
        load_word(C_LD_PGM, 14'h0333);
        cmd(C_ER_PG);
        cmd(C_INC);
        wait_idle();
        chk(err_cnt == 1, "R9 err_cnt after busy command", 32'(err_cnt), 1);
        read_frame(C_RD_PGM, got, ok);
        chk(got[14:1] == 14'h0333, "R9 increment ignored", 32'(got[14:1]), 32'h333);
    endtask

    task automatic t_bulk();
        int bad = 0;
        busy_seen = 0;
        cmd(C_BULK_P); wait_idle();
        for (int i = 0; i < 64; i++) if (puser[i] != 14'h3FFF) bad++;
        chk(bad == 0, "R10 bulk program words", bad, 0);
        chk(busy_seen == 64, "R10 bulk program busy", busy_seen, 64);
        busy_seen = 0; bad = 0;
        cmd(C_BULK_D); wait_idle();
        for (int i = 0; i < 128; i++) if (dmem[i] != 8'hFF) bad++;
        chk(bad == 0, "R10 bulk data bytes", bad, 0);
        chk(busy_seen == 128, "R10 bulk data busy", busy_seen, 128);
    endtask

    task automatic t_config();
        logic [15:0] got; bit ok;
        load_word(C_LD_CFG, 14'h0ABC); cmd(C_ER_PG); wait_idle();
        chk(pcfg[0] == 14'h0ABC, "R6 config base write", 32'(pcfg[0]), 32'hABC);
        incs(8);
        read_frame(C_RD_PGM, got, ok);
        chk(got[14:1] == 14'h3FFF, "R6 void config reads ones", 32'(got[14:1]), 32'h3FFF);
        load_word(C_LD_PGM, 14'h0000); cmd(C_ER_PG); wait_idle();
        chk(puser[8] == 14'h3FFF && pcfg[0] == 14'h0ABC, "R6 void config write dropped",
            32'(puser[8]), 32'h3FFF);
        incs(248);
        read_frame(C_RD_PGM, got, ok);
        chk(got[14:1] == 14'h0ABC, "R6 config wrap to base", 32'(got[14:1]), 32'hABC);
    endtask

    task automatic t_mode_exit();
        tick(1); mode_en = 0; tick(3); mode_en = 1; tick(3);
        load_word(C_LD_PGM, 14'h0055); cmd(C_ER_PG); wait_idle();
        chk(puser[0] == 14'h0055, "R11 PC back at user zero", 32'(puser[0]), 32'h55);
        chk(pcfg[0] == 14'h0ABC, "R11 config untouched", 32'(pcfg[0]), 32'hABC);
    endtask

    task automatic t_no_ops();
        logic [15:0] got; bit ok;
        busy_seen = 0;
        cmd(6'b111000); cmd(6'b000001); cmd(6'b000111);
        tick(4);
        chk(busy_seen == 0, "R12 no busy window", busy_seen, 0);
        chk(err_cnt == 1, "R12 err_cnt unchanged", 32'(err_cnt), 1);
        read_frame(C_RD_PGM, got, ok);
        chk(got[14:1] == 14'h0055 && ok, "R12 PC unchanged, no frame taken", 32'(got[14:1]), 32'h55);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) puser[i] = 14'h3FFF;
        for (int i = 0; i < 8; i++) pcfg[i] = 14'h3FFF;
        for (int i = 0; i < 128; i++) dmem[i] = 8'hFF;
        pmem_rdata = '0; dmem_rdata = '0;
        tick(4); rst = 0; tick(2);
        t_reset();
        mode_en = 1; tick(3);
        t_erase_program();
        t_read_program();
        t_program_only();
        t_data_mem();
        t_user_wrap();
        t_busy_reject();
        t_bulk();
        t_config();
        t_mode_exit();
        t_no_ops();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule